// File: doc/BRIEF.md
# ADC Sample Offset and Gain Correction

This block corrects raw converter samples by applying an offset trim and then a gain trim. Both trims come from 14-bit coefficient registers. A coefficient value of 0x2000 means no correction, and each step is a quarter of an output LSB. Samples enter and leave on valid/ready streams. The datapath has two register stages, carries two fractional bits, rounds half-up once at the end and clamps to the output code range instead of wrapping.

Software writes the two coefficients through a small register port, and a write never disturbs a sample already inside the pipeline. The input stream accepts a sample whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low while `out_valid` is high, the output word stays frozen and `in_ready` falls, so the whole pipeline stalls with no loss and no duplication. The parameter `SIGNED_IN` selects the sample format: two's complement (default) or offset binary. The checks below assume the default 16-bit signed configuration.

Top module: `adc_cal_corr`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, and reading either coefficient register (`reg_addr` 0 = offset, 1 = gain) returns 0x2000.
- R2: A write with `reg_wr` high lands in the register picked by `reg_addr` at the rising clock edge. `reg_rdata` shows the picked register combinationally. A register not written keeps its value.
- R3: With the gain at 0x2000, the output equals the input plus (offset − 0x2000)/4, rounded as in R5.
- R4: The offset-corrected value is multiplied by 1 + (gain − 0x2000)·2^-(SW+2), where SW = 16 is the sample width. The offset is applied before the gain.
- R5: Rounding to an integer code happens once, at the output. A value exactly halfway between two codes goes to the higher code, so +7.5 becomes 8 and −6.5 becomes −6.
- R6: Results above 32767 give 32767, and results below −32768 give −32768 (unsigned mode: 0 and 2^SW − 1).
- R7: With `out_ready` held high, a sample presented with `in_valid` high in cycle c appears with `out_valid` high in cycle c+2, and not in cycle c+1.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sample` hold. Every accepted sample leaves exactly once, in order.
- R9: A sample accepted at the same edge as a coefficient write, or earlier, is corrected with the old coefficients. Samples accepted at later edges use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_sample | input | SW | Raw converter sample |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_sample | output | SW | Corrected, rounded, clamped sample |
| reg_wr | input | 1 | Coefficient write strobe |
| reg_addr | input | 1 | 0 selects offset, 1 selects gain |
| reg_wdata | input | CW | Coefficient write data |
| reg_rdata | output | CW | Selected coefficient readback |

## Verification
Each coefficient is captured into the first stage alongside its sample. A coefficient latched at the wrong moment therefore shows up as a wrong value on the one sample that crosses a write, exactly two cycles after that sample is accepted. A lost or doubled valid bit shifts every later output against the expected order, so the very next comparison fails. A stall fault appears as a changed or missing output word in the cycle right after `out_ready` drops. A rounding or clamp fault appears only at exact half codes or at extreme inputs, so those cases are driven on purpose.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int unsigned COEF_W = 14;

  typedef enum logic {
    SEL_OFFSET = 1'b0,
    SEL_GAIN   = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/adc_cal_coef_regs.sv
module adc_cal_coef_regs
  import adc_cal_pkg::*;
#(
  parameter int CW = COEF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CW-1:0] ofs_q,
  output logic [CW-1:0] gain_q
);
  // mid-scale code: the "no correction" value
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  coef_sel_e sel;
  assign sel = coef_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q  <= MID;
      gain_q <= MID;
    end else if (wr_en) begin
      if (sel == SEL_OFFSET) ofs_q  <= wdata;
      else                   gain_q <= wdata;
    end
  end

  assign rdata = (sel == SEL_GAIN) ? gain_q : ofs_q;

  // R2: registers only move on a write strobe
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ofs_q) && $stable(gain_q));
endmodule

// File: rtl/adc_cal_offset_stage.sv
module adc_cal_offset_stage #(
  parameter int SW        = 16,
  parameter int CW        = 14,
  parameter int SIGNED_IN = 1,
  localparam int S1W      = SW + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  in_valid,
  input  logic [SW-1:0]         raw,
  input  logic [CW-1:0]         ofs,
  input  logic [CW-1:0]         gain,
  output logic                  v1,
  output logic signed [S1W-1:0] s1,
  output logic signed [CW-1:0]  gdelta
);
  logic signed [SW:0]      x_ext;
  logic signed [CW-1:0]    odelta;
  logic signed [S1W-1:0]   x_q;
  logic signed [S1W-1:0]   o_q;
  logic signed [S1W-1:0]   sum;

  generate
    if (SIGNED_IN != 0) begin : g_signed
      assign x_ext = {raw[SW-1], raw};
    end else begin : g_unsigned
      assign x_ext = {1'b0, raw};
    end
  endgenerate

  // flipping the top bit removes the mid-scale bias
  assign odelta = {~ofs[CW-1], ofs[CW-2:0]};
  assign x_q    = {x_ext[SW], x_ext, 2'b00};
  assign o_q    = {{(S1W-CW){odelta[CW-1]}}, odelta};
  assign sum    = x_q + o_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      s1     <= '0;
      gdelta <= '0;
    end else if (en) begin
      v1 <= in_valid;
      if (in_valid) begin
        s1     <= sum;
        gdelta <= {~gain[CW-1], gain[CW-2:0]};
      end
    end
  end

  // R7: stage valid follows the accepted input
  p_stage1_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> v1 == $past(in_valid));
  // R8: stalled stage keeps its contents
  p_stage1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(v1) && $stable(s1) && $stable(gdelta));
endmodule

// File: rtl/adc_cal_gain_stage.sv
module adc_cal_gain_stage #(
  parameter int SW        = 16,
  parameter int CW        = 14,
  parameter int SIGNED_IN = 1,
  localparam int S1W      = SW + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  v1,
  input  logic signed [S1W-1:0] s1,
  input  logic signed [CW-1:0]  gdelta,
  output logic                  v2,
  output logic [SW-1:0]         y
);
  localparam int GW = SW + 4;
  localparam int PW = S1W + GW;
  localparam int SH = SW + 4;

  localparam logic signed [GW-1:0] UNITY = {2'b01, {(SW+2){1'b0}}};
  localparam logic signed [PW-1:0] HALF  = {{(PW-SW-4){1'b0}}, 1'b1, {(SW+3){1'b0}}};
  localparam logic signed [PW-1:0] S_MAX = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] S_MIN = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};
  localparam logic signed [PW-1:0] U_MAX = {{(PW-SW){1'b0}}, {SW{1'b1}}};
  localparam logic signed [PW-1:0] U_MIN = '0;
  localparam logic signed [PW-1:0] MAXV  = (SIGNED_IN != 0) ? S_MAX : U_MAX;
  localparam logic signed [PW-1:0] MINV  = (SIGNED_IN != 0) ? S_MIN : U_MIN;

  logic signed [GW-1:0] g_full;
  logic signed [PW-1:0] s1_x;
  logic signed [PW-1:0] g_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rounded;
  logic signed [PW-1:0] scaled;
  logic [SW-1:0]        y_n;

  assign g_full  = UNITY + {{(GW-CW){gdelta[CW-1]}}, gdelta};
  assign s1_x    = {{GW{s1[S1W-1]}}, s1};
  assign g_x     = {{S1W{g_full[GW-1]}}, g_full};
  assign prod    = s1_x * g_x;
  assign rounded = prod + HALF;
  assign scaled  = rounded >>> SH;

  always_comb begin
    if (scaled > MAXV)      y_n = MAXV[SW-1:0];
    else if (scaled < MINV) y_n = MINV[SW-1:0];
    else                    y_n = scaled[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      y  <= '0;
    end else if (en) begin
      v2 <= v1;
      if (v1) y <= y_n;
    end
  end

  // R7: output valid follows stage-one valid
  p_stage2_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> v2 == $past(v1));
endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr
  import adc_cal_pkg::*;
#(
  parameter int SW        = 16,
  parameter int CW        = COEF_W,
  parameter int SIGNED_IN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_sample,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata
);
  localparam int S1W = SW + 4;

  logic                  adv;
  logic [CW-1:0]         ofs_q;
  logic [CW-1:0]         gain_q;
  logic                  v1;
  logic signed [S1W-1:0] s1;
  logic signed [CW-1:0]  gdelta;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  adc_cal_coef_regs #(.CW(CW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ofs_q (ofs_q),
    .gain_q(gain_q)
  );

  adc_cal_offset_stage #(.SW(SW), .CW(CW), .SIGNED_IN(SIGNED_IN)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (adv),
    .in_valid(in_valid),
    .raw     (in_sample),
    .ofs     (ofs_q),
    .gain    (gain_q),
    .v1      (v1),
    .s1      (s1),
    .gdelta  (gdelta)
  );

  adc_cal_gain_stage #(.SW(SW), .CW(CW), .SIGNED_IN(SIGNED_IN)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .v1    (v1),
    .s1    (s1),
    .gdelta(gdelta),
    .v2    (out_valid),
    .y     (out_sample)
  );

  // R8: a refused output word stays put
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample));
  // R8: no input taken while the output is blocked
  p_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(v1));
endmodule

// File: tb/sim_adc_cal_corr.sv
`timescale 1ns/1ps
module sim_adc_cal_corr;
  localparam int SW = 16;
  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_sample = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sample;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;

  int    n_checks = 0;
  int    n_errs = 0;
  int    cur_ofs = 8192;
  int    cur_gain = 8192;
  bit    bp_mode = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  adc_cal_corr #(.SW(SW), .CW(CW), .SIGNED_IN(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic int model(int x, int ofs, int gn);
    longint s, g, p, q;
    s = longint'(x) * 4 + longint'(ofs) - 8192;
    g = (longint'(1) << (SW + 2)) + longint'(gn) - 8192;
    p = s * g + (longint'(1) << (SW + 3));
    q = p >>> (SW + 4);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge after acceptance
  task automatic send(int x, string tag);
    in_valid  = 1'b1;
    in_sample = x[SW-1:0];
    exp_q.push_back(model(x, cur_ofs, cur_gain));
    tag_q.push_back(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(bit a, int v);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = v[CW-1:0];
    @(negedge clk);
    reg_wr = 1'b0;
    if (a) cur_gain = v;
    else   cur_ofs  = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit stalled = 1'b0;
    logic [SW-1:0] held = '0;
    forever begin
      @(negedge clk);
      out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (stalled) begin
        chk(out_valid === 1'b1, "R8", "valid held", out_valid, 1);
        chk(out_sample === held, "R8", "data held", out_sample, held);
      end
      chk(in_ready === (!out_valid || out_ready), "R8", "in_ready", in_ready,
          !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected output", $signed(out_sample), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'($signed(out_sample)) == e, t, "sample", $signed(out_sample), e);
        end
      end
      stalled = out_valid && !out_ready;
      held    = out_sample;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "valid after reset", out_valid, 0);
    reg_addr = 1'b0; #1;
    chk(reg_rdata == 14'h2000, "R1", "offset reset", reg_rdata, 14'h2000);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 14'h2000, "R1", "gain reset", reg_rdata, 14'h2000);
    @(negedge clk);

    // R2 write and readback
    wr(1'b0, 14'h2028);
    reg_addr = 1'b0; #1;
    chk(reg_rdata == 14'h2028, "R2", "offset readback", reg_rdata, 14'h2028);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 14'h2000, "R2", "gain untouched", reg_rdata, 14'h2000);
    @(negedge clk);

    // R3 offset only
    send(100, "R3");
    send(-5000, "R3");
    wr(1'b0, 14'h1F00);
    send(1234, "R3");
    send(0, "R3");

    // R5 half codes
    wr(1'b0, 14'h2002);
    send(7, "R5");
    send(-7, "R5");
    wr(1'b0, 14'h1FFE);
    send(7, "R5");
    send(-7, "R5");

    // R4 gain
    wr(1'b0, 14'h2000);
    wr(1'b1, 14'h3000);
    send(16384, "R4");
    send(-20000, "R4");
    wr(1'b1, 14'h0000);
    send(-32768, "R4");
    wr(1'b0, 14'h2100);
    send(3000, "R4");

    // R6 clamps
    wr(1'b1, 14'h3FFF);
    wr(1'b0, 14'h3FFF);
    send(32767, "R6");
    send(32000, "R6");
    wr(1'b0, 14'h0000);
    send(-32768, "R6");
    send(-32700, "R6");
    drain();
    wr(1'b0, 14'h2000);
    wr(1'b1, 14'h2000);

    // R7 latency
    in_valid = 1'b1;
    in_sample = 16'd321;
    exp_q.push_back(321);
    tag_q.push_back("R7");
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid === 1'b0, "R7", "valid at c+1", out_valid, 0);
    @(negedge clk);
    #1;
    chk(out_valid === 1'b1, "R7", "valid at c+2", out_valid, 1);
    drain();

    // R9 write in same cycle as acceptance: old coefficient used
    reg_wr = 1'b1;
    reg_addr = 1'b0;
    reg_wdata = 14'h2400;
    in_valid = 1'b1;
    in_sample = 16'd500;
    exp_q.push_back(model(500, cur_ofs, cur_gain));
    tag_q.push_back("R9");
    @(negedge clk);
    reg_wr = 1'b0;
    in_valid = 1'b0;
    cur_ofs = 14'h2400;
    send(500, "R9");
    // R9 in-flight samples keep old gain
    send(10000, "R9");
    wr(1'b1, 14'h1000);
    send(10000, "R9");
    drain();

    // R8 random stream under back-pressure
    bp_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (i % 37 == 5) wr(1'b0, int'($urandom_range(0, 16383)));
      if (i % 53 == 9) wr(1'b1, int'($urandom_range(0, 16383)));
      send(int'($urandom_range(0, 65535)) - 32768, "R8");
    end
    drain();
    bp_mode = 1'b0;
    chk(exp_q.size() == 0, "R8", "all outputs seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule